// File: doc/BRIEF.md
# Seven-to-one LVDS bit and word aligner

This controller brings up one receive channel of a seven-bit-per-clock LVDS link. A PLL outside the block offers sixteen sampling phases, and the deserializer delivers one 7-bit parallel word of the clock lane per word clock. The controller moves the sampling phase forward one position at a time through a request/acknowledge handshake. It watches bit 1 of the clock-lane word for changes, which marks each phase as stable or unstable. The phase is then parked in the middle of the widest stable stretch.

Once the phase is parked, the controller aligns the word boundary. It compares the clock-lane word with the framing pattern 7'b1100011. On a mismatch it pulses a slip request, which moves the deserializer's boundary by one bit. When the word matches, the controller raises its done flag and stays there until reset. If seven slips pass without a match, it drops lock and sweeps the phases again.

Top module: `lvds71_aligner`

## Requirements
- R1: A synchronous active-high reset sets phase_o to 0 and holds phase_req_o, slip_o, bit_lock_o and word_done_o low. The block then starts a sweep and assumes the PLL is at phase 0.
- R2: Each phase is watched for DWELL consecutive word clocks, 64 by default. A phase counts as stable only if bit 1 of clk_word_i keeps the same value across every pair of consecutive samples in that window.
- R3: A phase step raises phase_req_o and holds it until phase_ack_i is sampled high. phase_o changes only on a cycle with both signals high, and then advances by one modulo 16.
- R4: A sweep watches 16 phases, starting at the current phase and stepping after each window. Among the runs of stable phases it picks the longest. On a tie it picks the run whose last phase comes first, counted from phase 0. The target is start + (length-1)/2. When all 16 phases are stable, the target is 7.
- R5: A stable run that crosses from phase 15 to phase 0 is a single run, and its centre is computed modulo 16.
- R6: If a sweep finds no stable phase, another sweep starts at once from the current phase, with lock low.
- R7: The block steps forward to the target phase and then raises bit_lock_o. It waits SETTLE word clocks (4 by default) before each compare, including the first. After each mismatch it sends a single-cycle slip_o pulse, and no phase request is made while locked.
- R8: When the sampled clock-lane word equals 7'b1100011 (bit 6 first), word_done_o rises and stays high until reset.
- R9: If the word still does not match after seven slips, bit_lock_o falls and a new sweep starts from the current phase.
- R10: Asserting reset in the middle of a sweep returns the block to the state of R1, and training then finishes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous reset, active high |
| clk_word_i | input | 7 | Deserialized clock-lane word |
| phase_req_o | output | 1 | Request to advance the PLL phase by one |
| phase_ack_i | input | 1 | PLL acknowledge of a phase step |
| phase_o | output | 4 | Phase the block believes the PLL is at |
| slip_o | output | 1 | One-bit word-boundary slip request |
| bit_lock_o | output | 1 | Sampling phase parked at the window centre |
| word_done_o | output | 1 | Word alignment finished |

## Verification
The assertions check the following on every cycle:
- the step handshake: phase changes only on an acknowledged request, always by one, and a request is held until it is acknowledged;
- slips are single-cycle pulses issued only while locked;
- done is sticky and rises only on a matching word;
- no phase request is made under lock.

Which phase the block picks as the centre for a given eye, the wrapped and tied windows, and the resweep after an empty map or after seven failed slips depend on sequences of stimulus. Only the bench's scenarios show these, by counting handshakes and slips and by comparing each cycle with a behavioural model.

// File: rtl/lvds71_aligner.sv
module lvds71_aligner #(
  parameter int PHASES = 16,
  parameter int WORD_W = 7,
  parameter int DWELL = 64,
  parameter int SETTLE = 4,
  parameter int MAX_SLIPS = 7,
  parameter logic [WORD_W-1:0] PATTERN = 7'b1100011
) (
  input  logic clk,
  input  logic rst,
  input  logic [WORD_W-1:0] clk_word_i,
  output logic phase_req_o,
  input  logic phase_ack_i,
  output logic [$clog2(PHASES)-1:0] phase_o,
  output logic slip_o,
  output logic bit_lock_o,
  output logic word_done_o
);
  localparam int PW = $clog2(PHASES);
  localparam int CW = $clog2((DWELL > SETTLE ? DWELL : SETTLE) + 1);
  localparam int SW = $clog2(MAX_SLIPS + 1);

  typedef enum logic [2:0] {OBSERVE, STEP, PICK, MOVE, SETTLE_W, SLIP, DONE} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] nobs, target, centre;
  logic [SW-1:0] nslip;
  logic prev_b, seen, any_good;
  logic [PHASES-1:0] good;

  wire edge_now = (cnt != '0) && (clk_word_i[1] != prev_b);
  wire last_dwell = cnt == CW'(DWELL - 1);
  wire hs = phase_req_o && phase_ack_i;
  wire [PW-1:0] phase_nx = (phase_o == PW'(PHASES - 1)) ? '0 : phase_o + 1'b1;

  assign phase_req_o = (st == STEP) || (st == MOVE);
  assign slip_o = st == SLIP;
  assign bit_lock_o = (st == SETTLE_W) || (st == SLIP) || (st == DONE);
  assign word_done_o = st == DONE;

  always_comb begin
    int run, best, bend;
    run = 0;
    best = 0;
    bend = 0;
    for (int i = 0; i < 2 * PHASES; i++) begin
      if (good[PW'(i % PHASES)]) begin
        if (run < PHASES) run = run + 1;
      end else begin
        run = 0;
      end
      if (run > best) begin
        best = run;
        bend = i % PHASES;
      end
    end
    any_good = best != 0;
    centre = PW'((bend - best + 1 + (best - 1) / 2 + PHASES) % PHASES);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= OBSERVE;
      cnt <= '0;
      nobs <= '0;
      nslip <= '0;
      prev_b <= 1'b0;
      seen <= 1'b0;
      good <= '0;
      phase_o <= '0;
      target <= '0;
    end else begin
      case (st)
        OBSERVE: begin
          prev_b <= clk_word_i[1];
          if (last_dwell) begin
            good[phase_o] <= !(seen || edge_now);
            seen <= 1'b0;
            cnt <= '0;
            if (nobs == PW'(PHASES - 1)) begin
              nobs <= '0;
              st <= PICK;
            end else begin
              nobs <= nobs + 1'b1;
              st <= STEP;
            end
          end else begin
            seen <= seen || edge_now;
            cnt <= cnt + 1'b1;
          end
        end
        STEP: if (hs) begin
          phase_o <= phase_nx;
          st <= OBSERVE;
        end
        PICK: begin
          target <= centre;
          if (!any_good) st <= OBSERVE;
          else if (centre == phase_o) st <= SETTLE_W;
          else st <= MOVE;
        end
        MOVE: if (hs) begin
          phase_o <= phase_nx;
          if (phase_nx == target) st <= SETTLE_W;
        end
        SETTLE_W: begin
          if (cnt == CW'(SETTLE - 1)) begin
            cnt <= '0;
            if (clk_word_i == PATTERN) begin
              st <= DONE;
            end else if (nslip == SW'(MAX_SLIPS)) begin
              nslip <= '0;
              st <= OBSERVE;
            end else begin
              st <= SLIP;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SLIP: begin
          nslip <= nslip + 1'b1;
          st <= SETTLE_W;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/lvds71_aligner_chk.sv
module lvds71_aligner_chk #(
  parameter int PHASES = 16,
  parameter int PW = 4,
  parameter int WORD_W = 7,
  parameter logic [WORD_W-1:0] PATTERN = 7'b1100011
) (
  input logic clk,
  input logic rst,
  input logic [WORD_W-1:0] clk_word_i,
  input logic phase_req_o,
  input logic phase_ack_i,
  input logic [PW-1:0] phase_o,
  input logic slip_o,
  input logic bit_lock_o,
  input logic word_done_o
);
  assert_step_on_handshake_R3: assert property (@(posedge clk) disable iff (rst)
    !$stable(phase_o) |-> $past(phase_req_o && phase_ack_i));

  assert_step_by_one_R3: assert property (@(posedge clk) disable iff (rst)
    $past(phase_req_o && phase_ack_i) |->
      phase_o == (($past(phase_o) == PW'(PHASES - 1)) ? PW'(0) : PW'($past(phase_o) + 1'b1)));

  assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
    phase_req_o && !phase_ack_i |=> phase_req_o);

  assert_slip_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    slip_o |=> !slip_o);

  assert_slip_locked_R7: assert property (@(posedge clk) disable iff (rst)
    slip_o |-> bit_lock_o && !word_done_o);

  assert_no_req_locked_R7: assert property (@(posedge clk) disable iff (rst)
    bit_lock_o |-> !phase_req_o);

  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    word_done_o |=> word_done_o);

  assert_done_on_match_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(word_done_o) |-> $past(clk_word_i) == PATTERN);
endmodule

bind lvds71_aligner lvds71_aligner_chk #(
  .PHASES(PHASES), .PW(PW), .WORD_W(WORD_W), .PATTERN(PATTERN)
) u_chk (
  .clk(clk), .rst(rst), .clk_word_i(clk_word_i), .phase_req_o(phase_req_o),
  .phase_ack_i(phase_ack_i), .phase_o(phase_o), .slip_o(slip_o),
  .bit_lock_o(bit_lock_o), .word_done_o(word_done_o)
);

// File: tb/tb_lvds71_aligner.sv
module tb_lvds71_aligner;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL = 16;
  localparam int SETTLE = 4;
  localparam logic [6:0] PAT = 7'b1100011;

  logic clk = 0, rst = 1;
  logic [6:0] clk_word;
  logic phase_ack;
  logic phase_req, slip, lock, done;
  logic [3:0] phase;

  lvds71_aligner #(.DWELL(DWELL), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst(rst), .clk_word_i(clk_word), .phase_req_o(phase_req),
    .phase_ack_i(phase_ack), .phase_o(phase), .slip_o(slip),
    .bit_lock_o(lock), .word_done_o(done));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [15:0] eye = '0;
  int off_init = 0, off = 0;
  bit bad = 0, tog = 0, started = 0;
  logic [3:0] pll_ph;
  int hs_n = 0, sl_n = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [6:0] rotw(input int k);
    logic [6:0] w = PAT;
    for (int i = 0; i < k; i++) w = {w[5:0], w[6]};
    return w;
  endfunction

  // PLL and deserializer stand-ins
  always @(posedge clk) begin
    tog <= ~tog;
    if (rst) begin
      pll_ph <= '0;
      phase_ack <= 1'b0;
      off <= off_init;
    end else begin
      phase_ack <= phase_req && !phase_ack;
      if (phase_req && phase_ack) pll_ph <= pll_ph + 1'b1;
      if (slip) off <= (off + 1) % 7;
    end
  end

  always_comb begin
    clk_word = bad ? 7'b0 : rotw(off);
    if (!eye[pll_ph]) clk_word[1] = tog;
  end

  // reference model: window choice
  function automatic int pick(input logic [15:0] m, output bit found);
    int best = 0, key = 0, st = 0;
    found = m != 0;
    if (m == 16'hFFFF) return 7;
    for (int s = 0; s < 16; s++) begin
      if (m[s] && !m[(s + 15) % 16]) begin
        int len = 0;
        while (len < 16 && m[(s + len) % 16]) len++;
        if (len > best || (len == best && s + len - 1 < key)) begin
          best = len; key = s + len - 1; st = s;
        end
      end
    end
    return (st + (best - 1) / 2) % 16;
  endfunction

  int m_mode, m_cnt, m_obs, m_slips, m_ph, m_tgt;
  bit m_prev, m_hit, m_found;
  logic [15:0] m_map;

  always @(posedge clk) begin
    if (rst) begin
      m_mode = 0; m_cnt = 0; m_obs = 0; m_slips = 0; m_ph = 0;
      m_hit = 0; m_prev = 0; m_map = '0; m_tgt = 0;
      started = 1;
    end else begin
      case (m_mode)
        0: begin
          if (m_cnt > 0 && clk_word[1] != m_prev) m_hit = 1;
          m_prev = clk_word[1];
          m_cnt++;
          if (m_cnt == DWELL) begin
            m_map[m_ph] = !m_hit;
            m_hit = 0; m_cnt = 0; m_obs++;
            if (m_obs == 16) begin m_obs = 0; m_mode = 2; end
            else m_mode = 1;
          end
        end
        1: if (phase_ack) begin m_ph = (m_ph + 1) % 16; m_mode = 0; end
        2: begin
          m_tgt = pick(m_map, m_found);
          if (!m_found) m_mode = 0;
          else m_mode = (m_tgt == m_ph) ? 4 : 3;
        end
        3: if (phase_ack) begin
          m_ph = (m_ph + 1) % 16;
          if (m_ph == m_tgt) m_mode = 4;
        end
        4: begin
          m_cnt++;
          if (m_cnt == SETTLE) begin
            m_cnt = 0;
            if (clk_word == PAT) m_mode = 6;
            else if (m_slips == 7) begin m_slips = 0; m_mode = 0; end
            else m_mode = 5;
          end
        end
        5: begin m_slips++; m_mode = 4; end
        default: ;
      endcase
    end
  end

  // compare against the model every cycle, and count port events
  always @(negedge clk) begin
    if (rst) begin
      hs_n = 0; sl_n = 0;
    end else begin
      if (phase_req && phase_ack) hs_n++;
      if (slip) sl_n++;
    end
    if (started) begin
      chk(int'(phase) == m_ph, "R3 cycle phase", phase, m_ph);
      chk(phase_req == (m_mode == 1 || m_mode == 3), "R3 cycle req", phase_req, m_mode);
      chk(slip == (m_mode == 5), "R7 cycle slip", slip, m_mode);
      chk(lock == (m_mode >= 4), "R7 cycle lock", lock, m_mode);
      chk(done == (m_mode == 6), "R8 cycle done", done, m_mode);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    chk(phase == 0 && !phase_req && !slip && !lock && !done, tag,
        {phase, phase_req, slip, lock, done}, 0);
    rst = 0;
  endtask

  task automatic finish_chk(input string tag, input int c, input int sl, input int hs);
    for (int i = 0; i < 20000 && !done; i++) @(negedge clk);
    chk(done, {tag, " R8 done"}, done, 1);
    chk(int'(phase) == c, {tag, " R4 centre"}, phase, c);
    chk(sl_n == sl, {tag, " R7 slips"}, sl_n, sl);
    chk(hs_n == hs, {tag, " R3 handshakes"}, hs_n, hs);
    chk(clk_word == PAT, {tag, " R8 word"}, clk_word, PAT);
  endtask

  initial begin
    // A: eye 5..10, centre 7
    eye = 16'b0000_0111_1110_0000; off_init = 3; bad = 0;
    do_reset("R1 reset state");
    finish_chk("A R2", 7, 4, 23);
    repeat (10) @(negedge clk);
    chk(done && lock, "R8 done held", done, 1);

    // B: window wraps 13..2, centre 15
    eye = 16'b1110_0000_0000_0111; off_init = 6;
    do_reset("R1 reset B");
    finish_chk("B R5", 15, 1, 15);

    // C: two windows, wider 8..12 wins
    eye = 16'b0001_1111_0001_1100; off_init = 0;
    do_reset("R1 reset C");
    finish_chk("C R4", 10, 0, 26);

    // D: every phase stable
    eye = 16'hFFFF; off_init = 5;
    do_reset("R1 reset D");
    finish_chk("D R4 all", 7, 2, 23);

    // H: tie 1..3 vs 9..11, earlier end wins
    eye = 16'b0000_1110_0000_1110; off_init = 2;
    do_reset("R1 reset H");
    finish_chk("H R4 tie", 2, 5, 18);

    // E: empty map on first sweep
    eye = '0; off_init = 1;
    do_reset("R1 reset E");
    for (int i = 0; i < 5000 && m_mode != 2; i++) @(negedge clk);
    chk(!lock, "R6 no lock on empty map", lock, 0);
    eye = 16'b0000_0111_1110_0000;
    repeat (2) @(negedge clk);
    chk(!lock && !done, "R6 resweep", lock, 0);
    finish_chk("E R6", 7, 6, 39);

    // F: word never matches, seven slips then resweep
    eye = 16'b0000_0111_1110_0000; off_init = 0; bad = 1;
    do_reset("R1 reset F");
    for (int i = 0; i < 5000 && !lock; i++) @(negedge clk);
    for (int i = 0; i < 5000 && lock; i++) @(negedge clk);
    chk(!lock, "R9 lock dropped", lock, 0);
    chk(sl_n == 7, "R9 slip count", sl_n, 7);
    chk(!done, "R9 not done", done, 0);
    bad = 0;
    finish_chk("F R9", 7, 7, 39);

    // G: reset in mid sweep
    eye = 16'b0000_0111_1110_0000; off_init = 3;
    do_reset("R1 reset G");
    repeat (60) @(negedge clk);
    do_reset("R10 mid-run reset");
    finish_chk("G R10", 7, 4, 23);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule